// File: doc/BRIEF.md
# Supply Voltage Status Monitor

This block turns two sampled voltage codes, one for the main supply rail and one for the auxiliary rail, into a registered 8-bit power status byte and a separate low-voltage safe flag. A power-management controller reads the byte to learn whether the rail is present, whether detection is running, whether the auxiliary rail is up and whether the device is sourcing or sinking. The controller also reads an initialization-busy bit and waits for it to clear before it trusts the other status fields.

Supply-present detection uses two thresholds. The bit sets when the rail code rises strictly above the rising threshold. It clears when the code drops strictly below the lower falling threshold. Inside the band between the two, the bit keeps its last value. A three-state machine tracks this: `DET_OFF` (detection disabled), `DET_LOW` (rail absent) and `DET_HIGH` (rail present). The transitions are:
- `DET_LOW`→`DET_HIGH` on a rise above the rising threshold.
- `DET_HIGH`→`DET_LOW` on a drop below the falling threshold.
- Any state →`DET_OFF` when detection is disabled.
- `DET_OFF`→`DET_HIGH` or `DET_LOW` on re-enable, chosen directly from the current code.

A second machine handles startup. It stays in `INIT_BUSY` for a fixed number of cycles after reset, then moves once to `INIT_READY` and remains there.

The source, sink and debug-accessory states come in as plain input flags. Every bit appears one clock edge after its inputs. All thresholds are parameters given as ADC codes. With the defaults, 1 LSB is 5 mV: rise 800 (4.0 V), fall 700 (3.5 V), safe 160 (0.8 V), auxiliary 480 (2.4 V).

Top module: `pwr_status_mon`

## Requirements
- R1: While reset is asserted, `status` is 8'h48 and `safe0` is 0. In that value, bit 6 (init busy) and bit 3 (detection enabled) are 1 and every other bit is 0.
- R2: With detection enabled, status bit 2 (supply present) goes from 0 to 1 one edge after `rail_code` is strictly greater than TH_RISE. A code equal to TH_RISE leaves it at 0.
- R3: While `rail_code` lies within [TH_FALL, TH_RISE], status bit 2 keeps its previous value.
- R4: Status bit 2 goes to 0 one edge after `rail_code` is strictly less than TH_FALL. A code equal to TH_FALL leaves it set.
- R5: `safe0` is 1 one edge after `rail_code` is strictly below TH_SAFE0 with detection enabled. Otherwise it is 0.
- R6: When `det_en` is 0, status bit 3 is 0, status bit 2 is 0 and `safe0` is 0 from the next edge on. When detection is enabled again, bit 2 is decided from the code alone: 1 if the code is above TH_RISE.
- R7: Status bit 1 (auxiliary present) is 1 one edge after `aux_en` is 1 and `aux_code` is strictly above TH_AUX. Otherwise it is 0.
- R8: Status bit 5 (nondefault voltage) is 1 only when `src_nondef` and `src_active` were both 1 at the previous edge. Status bit 4 follows `src_active`.
- R9: Status bit 7 follows `dbg_attached` and status bit 0 follows `snk_active`, each one edge later.
- R10: Status bit 6 stays 1 for exactly INIT_CYCLES edges after reset is released, then becomes 0 and stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_code | input | CODE_W | Sampled main supply rail code |
| aux_code | input | CODE_W | Sampled auxiliary rail code |
| det_en | input | 1 | Enables supply-rail detection |
| aux_en | input | 1 | Auxiliary supply enable |
| src_active | input | 1 | Device is sourcing the supply |
| src_nondef | input | 1 | Sourcing a nondefault voltage |
| snk_active | input | 1 | Device is sinking the supply |
| dbg_attached | input | 1 | Debug accessory attached |
| status | output | 8 | Power status byte |
| safe0 | output | 1 | Rail is at the low safe level |

## Verification
The assertions check, on every cycle, the rules that link bits or link an input to the next output:
- supply present and safe0 never appear while detection is off;
- nondefault voltage never appears without sourcing;
- auxiliary present never appears without its enable;
- the rising, holding and falling rules of the hysteresis;
- the busy bit never returns once it has cleared.

Only the bench's scenarios can show the rest:
- the exact boundary codes at each threshold;
- the value after reset;
- the exact length of the busy period;
- the re-entry decision after detection is enabled again.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;
    typedef enum logic [1:0] {
        DET_OFF  = 2'd0,
        DET_LOW  = 2'd1,
        DET_HIGH = 2'd2
    } det_state_e;

    typedef enum logic {
        INIT_BUSY  = 1'b0,
        INIT_READY = 1'b1
    } init_state_e;

    localparam int BIT_DBG    = 7;
    localparam int BIT_BUSY   = 6;
    localparam int BIT_NONDEF = 5;
    localparam int BIT_SRC    = 4;
    localparam int BIT_DETEN  = 3;
    localparam int BIT_PRES   = 2;
    localparam int BIT_AUX    = 1;
    localparam int BIT_SNK    = 0;
endpackage

// File: rtl/pwr_rail_hyst.sv
module pwr_rail_hyst
    import pwr_mon_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int TH_RISE = 800,
    parameter int TH_FALL = 700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              present
);
    localparam logic [CODE_W-1:0] RISE_C = CODE_W'(TH_RISE);
    localparam logic [CODE_W-1:0] FALL_C = CODE_W'(TH_FALL);

    det_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DET_LOW;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            DET_OFF: begin
                if (en) nxt = (code > RISE_C) ? DET_HIGH : DET_LOW;
            end
            DET_LOW: begin
                if (!en)               nxt = DET_OFF;
                else if (code > RISE_C) nxt = DET_HIGH;
            end
            DET_HIGH: begin
                if (!en)               nxt = DET_OFF;
                else if (code < FALL_C) nxt = DET_LOW;
            end
            default: nxt = DET_LOW;
        endcase
    end

    always_comb present = (state == DET_HIGH);
endmodule

// File: rtl/pwr_level_flag.sv
module pwr_level_flag #(
    parameter int CODE_W = 10,
    parameter int TH     = 160,
    parameter bit ABOVE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              flag
);
    localparam logic [CODE_W-1:0] TH_C = CODE_W'(TH);

    logic hit;

    generate
        if (ABOVE) begin : g_above
            always_comb hit = (code > TH_C);
        end else begin : g_below
            always_comb hit = (code < TH_C);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= en & hit;
    end
endmodule

// File: rtl/pwr_init_seq.sv
module pwr_init_seq
    import pwr_mon_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(INIT_CYCLES) + 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    init_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT_BUSY;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == INIT_BUSY && cnt != LAST) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            INIT_BUSY:  if (cnt == LAST) nxt = INIT_READY;
            INIT_READY: nxt = INIT_READY;
            default:    nxt = INIT_BUSY;
        endcase
    end

    always_comb busy = (state == INIT_BUSY);
endmodule

// File: rtl/pwr_status_mon.sv
module pwr_status_mon
    import pwr_mon_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int TH_RISE     = 800,
    parameter int TH_FALL     = 700,
    parameter int TH_SAFE0    = 160,
    parameter int TH_AUX      = 480,
    parameter int INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rail_code,
    input  logic [CODE_W-1:0] aux_code,
    input  logic              det_en,
    input  logic              aux_en,
    input  logic              src_active,
    input  logic              src_nondef,
    input  logic              snk_active,
    input  logic              dbg_attached,
    output logic [7:0]        status,
    output logic              safe0
);
    logic pres, aux_ok, busy;
    logic dbg_q, src_q, nondef_q, snk_q, deten_q;

    pwr_rail_hyst #(.CODE_W(CODE_W), .TH_RISE(TH_RISE), .TH_FALL(TH_FALL)) u_hyst (
        .clk(clk), .rst_n(rst_n), .en(det_en), .code(rail_code), .present(pres)
    );

    pwr_level_flag #(.CODE_W(CODE_W), .TH(TH_SAFE0), .ABOVE(1'b0)) u_safe0 (
        .clk(clk), .rst_n(rst_n), .en(det_en), .code(rail_code), .flag(safe0)
    );

    pwr_level_flag #(.CODE_W(CODE_W), .TH(TH_AUX), .ABOVE(1'b1)) u_aux (
        .clk(clk), .rst_n(rst_n), .en(aux_en), .code(aux_code), .flag(aux_ok)
    );

    pwr_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk(clk), .rst_n(rst_n), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_q    <= 1'b0;
            src_q    <= 1'b0;
            nondef_q <= 1'b0;
            snk_q    <= 1'b0;
            deten_q  <= 1'b1;
        end else begin
            dbg_q    <= dbg_attached;
            src_q    <= src_active;
            nondef_q <= src_active & src_nondef;
            snk_q    <= snk_active;
            deten_q  <= det_en;
        end
    end

    always_comb begin
        status             = '0;
        status[BIT_DBG]    = dbg_q;
        status[BIT_BUSY]   = busy;
        status[BIT_NONDEF] = nondef_q;
        status[BIT_SRC]    = src_q;
        status[BIT_DETEN]  = deten_q;
        status[BIT_PRES]   = pres;
        status[BIT_AUX]    = aux_ok;
        status[BIT_SNK]    = snk_q;
    end
endmodule

// File: rtl/pwr_status_mon_chk.sv
module pwr_status_mon_chk #(
    parameter int CODE_W      = 10,
    parameter int TH_RISE     = 800,
    parameter int TH_FALL     = 700,
    parameter int TH_SAFE0    = 160,
    parameter int TH_AUX      = 480,
    parameter int INIT_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] rail_code,
    input logic [CODE_W-1:0] aux_code,
    input logic              det_en,
    input logic              aux_en,
    input logic              src_active,
    input logic              src_nondef,
    input logic              snk_active,
    input logic              dbg_attached,
    input logic [7:0]        status,
    input logic              safe0
);
    localparam logic [CODE_W-1:0] RISE_C = CODE_W'(TH_RISE);
    localparam logic [CODE_W-1:0] FALL_C = CODE_W'(TH_FALL);

    AST_PRES_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[3]); // R6
    AST_SAFE0_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        safe0 |-> status[3]); // R6
    AST_DET_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (!status[2] && !safe0 && !status[3])); // R6
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && rail_code > RISE_C) |=> status[2]); // R2
    AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && status[3] && rail_code >= FALL_C && rail_code <= RISE_C) |=> $stable(status[2])); // R3
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_code < FALL_C) |=> !status[2]); // R4
    AST_AUX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_en |=> !status[1]); // R7
    AST_NONDEF_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |-> status[4]); // R8
    AST_BUSY_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !status[6] |=> !status[6]); // R10
endmodule

bind pwr_status_mon pwr_status_mon_chk #(
    .CODE_W(CODE_W), .TH_RISE(TH_RISE), .TH_FALL(TH_FALL),
    .TH_SAFE0(TH_SAFE0), .TH_AUX(TH_AUX), .INIT_CYCLES(INIT_CYCLES)
) u_chk (.*);

// File: tb/tb_pwr_status_mon.sv
module tb_pwr_status_mon;
    localparam int CODE_W = 10;
    localparam int RISE   = 800;
    localparam int FALL   = 700;
    localparam int SAFE   = 160;
    localparam int AUXT   = 480;
    localparam int INITC  = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic [CODE_W-1:0] rail_code, aux_code;
    logic det_en, aux_en, src_active, src_nondef, snk_active, dbg_attached;
    logic [7:0] status;
    logic safe0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_status_mon #(
        .CODE_W(CODE_W), .TH_RISE(RISE), .TH_FALL(FALL),
        .TH_SAFE0(SAFE), .TH_AUX(AUXT), .INIT_CYCLES(INITC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rail_code(rail_code), .aux_code(aux_code),
        .det_en(det_en), .aux_en(aux_en), .src_active(src_active),
        .src_nondef(src_nondef), .snk_active(snk_active),
        .dbg_attached(dbg_attached), .status(status), .safe0(safe0)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rail_code = '0; aux_code = '0; det_en = 1'b1; aux_en = 1'b0;
        src_active = 1'b0; src_nondef = 1'b0; snk_active = 1'b0; dbg_attached = 1'b0;
        step(); step();
        chk("R1 status", status, 8'h48);
        chk("R1 safe0", safe0, 0);
        rail_code = 10'd500;
        rst_n = 1'b1;
        for (int i = 0; i < INITC - 1; i++) step();
        chk("R10 busy before end", status[6], 1);
        step();
        chk("R10 busy cleared", status[6], 0);
        step(); step();
        chk("R10 busy stays clear", status[6], 0);
    endtask

    task automatic t_hyst();
        rail_code = 10'(RISE); step();
        chk("R2 equal rise stays low", status[2], 0);
        rail_code = 10'(RISE + 1); step();
        chk("R2 above rise sets", status[2], 1);
        rail_code = 10'd750; step();
        chk("R3 band holds high", status[2], 1);
        rail_code = 10'(FALL); step();
        chk("R4 equal fall holds", status[2], 1);
        rail_code = 10'(FALL - 1); step();
        chk("R4 below fall clears", status[2], 0);
        rail_code = 10'd790; step();
        chk("R3 band holds low", status[2], 0);
    endtask

    task automatic t_safe0();
        rail_code = 10'(SAFE - 1); step();
        chk("R5 below safe", safe0, 1);
        chk("R5 present low", status[2], 0);
        rail_code = 10'(SAFE); step();
        chk("R5 equal safe", safe0, 0);
    endtask

    task automatic t_detdis();
        rail_code = 10'd900; step();
        chk("R6 present before disable", status[2], 1);
        det_en = 1'b0; step();
        chk("R6 detect bit off", status[3], 0);
        chk("R6 present forced off", status[2], 0);
        rail_code = 10'd10; step();
        chk("R6 safe0 forced off", safe0, 0);
        rail_code = 10'd900; det_en = 1'b1; step();
        chk("R6 reenable present", status[2], 1);
        chk("R6 reenable detect bit", status[3], 1);
        rail_code = 10'd750; det_en = 1'b0; step();
        det_en = 1'b1; step();
        chk("R6 reenable in band low", status[2], 0);
    endtask

    task automatic t_aux();
        aux_en = 1'b1; aux_code = 10'(AUXT + 1); step();
        chk("R7 aux above", status[1], 1);
        aux_code = 10'(AUXT); step();
        chk("R7 aux equal", status[1], 0);
        aux_code = 10'd600; aux_en = 1'b0; step();
        chk("R7 aux disabled", status[1], 0);
    endtask

    task automatic t_nondef();
        src_nondef = 1'b1; src_active = 1'b0; step();
        chk("R8 nondef without sourcing", status[5], 0);
        src_active = 1'b1; step();
        chk("R8 nondef with sourcing", status[5], 1);
        chk("R8 sourcing bit", status[4], 1);
        src_nondef = 1'b0; step();
        chk("R8 nondef dropped", status[5], 0);
        src_active = 1'b0;
    endtask

    task automatic t_flags();
        rail_code = 10'd500;
        dbg_attached = 1'b1; snk_active = 1'b1; step();
        chk("R9 dbg and sink byte", status, 8'h89);
        dbg_attached = 1'b0; step();
        chk("R9 dbg cleared", status, 8'h09);
        snk_active = 1'b0; step();
        chk("R9 sink cleared", status, 8'h08);
    endtask

    initial begin
        t_reset();
        t_hyst();
        t_safe0();
        t_detdis();
        t_aux();
        t_nondef();
        t_flags();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule